// File: doc/BRIEF.md
# Circular-Buffer DMA Sample Address Generator

This block places converter samples into a circular region of memory, one word per sample, through a request/grant handshake with the processor. Software first programs a start address and a region length. Each is held in its own register and feeds its own counter: a current-address counter and a remaining-words counter.

When a sample arrives, the block captures its data and raises a DMA request. When the processor grants the request, the block drives a single write strobe with the current address and the captured data. It then advances the address by one and reduces the remaining count by one. The transfer that uses up the region reloads both counters from the held values and raises a one-cycle wrap pulse, which tells software that one pass over the buffer is complete.

A programmed length of zero disables the buffer. In that state, incoming samples are ignored.

Top module: `dma_ring_addr`

## Requirements
- R1: A write to the start or length register while no request is pending also loads the matching counter, so the next transfer uses the new start address and the new length.
- R2: A sample (sample_valid high for one cycle) arriving with no request pending and a nonzero programmed length raises dma_req at the next clock edge. dma_req then stays high until a cycle in which dma_gnt is high.
- R3: dma_gnt while dma_req is low has no effect. Each honoured grant produces exactly one mem_we pulse, one cycle long, in the cycle after the grant, and dma_req falls in that same cycle.
- R4: During the mem_we pulse, mem_addr holds the address counter value and mem_wdata holds the data captured with the sample.
- R5: After a transfer that does not exhaust the region, the next transfer's address is one higher.
- R6: The transfer that brings the remaining count from one to zero raises wrap together with its mem_we pulse. The next transfer then uses the held start address, and a full pass again takes the held length.
- R7: Writing the start register while a request is pending changes only the held value. The pending and following transfers keep stepping from the current address, and the new start takes effect at the next reload.
- R8: While the programmed length is zero, a sample raises no request and produces no write.
- R9: After reset, dma_req, mem_we and wrap are low, mem_addr is zero and the programmed length is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start_we | input | 1 | Write strobe for the start-address register |
| cfg_start | input | AW | Start address value |
| cfg_len_we | input | 1 | Write strobe for the region-length register |
| cfg_len | input | LW | Region length in words; zero disables the buffer |
| sample_valid | input | 1 | One-cycle pulse when a new sample is present |
| sample_data | input | DW | Sample value |
| dma_req | output | 1 | DMA request to the processor |
| dma_gnt | input | 1 | DMA grant from the processor |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| wrap | output | 1 | One-cycle pulse on the transfer that completes a pass |

## Verification
The bench goes after the reload boundary: the wrap pulse must sit on the last word, and the address that follows must be the held start. An off-by-one in the remaining count shows up as a pass that is one word too long or too short, and a missing reload shows up as an address that keeps climbing. It also sends grants with no request pending, which a careless design would turn into stray strobes. It varies the grant latency to catch a request that drops too early. It writes the start register during a pending request, where a design that loads the counter at once would jump addresses in the middle of a pass. Finally it covers a single-word region, where every transfer wraps, and a disabled region, where a design that did not gate on a zero length would raise requests anyway.

// File: rtl/dma_ring_addr.sv
module dma_ring_addr #(
  parameter int AW = 16,
  parameter int LW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_start_we,
  input  logic [AW-1:0] cfg_start,
  input  logic          cfg_len_we,
  input  logic [LW-1:0] cfg_len,
  input  logic          sample_valid,
  input  logic [DW-1:0] sample_data,
  output logic          dma_req,
  input  logic          dma_gnt,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          wrap
);
  logic [AW-1:0] start_q, addr_cnt;
  logic [LW-1:0] len_q, rem_cnt;
  logic [DW-1:0] data_q;

  wire idle = !dma_req;
  wire xfer = dma_req && dma_gnt;
  wire last = (rem_cnt == LW'(1));
  wire take = sample_valid && idle && (len_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q   <= '0;
      len_q     <= '0;
      addr_cnt  <= '0;
      rem_cnt   <= '0;
      data_q    <= '0;
      dma_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      wrap      <= 1'b0;
    end else begin
      mem_we <= xfer;
      wrap   <= xfer && last;
      if (xfer) begin
        mem_addr  <= addr_cnt;
        mem_wdata <= data_q;
      end

      if (take) begin
        dma_req <= 1'b1;
        data_q  <= sample_data;
      end else if (xfer) begin
        dma_req <= 1'b0;
      end

      if (cfg_start_we) start_q <= cfg_start;
      if (cfg_len_we)   len_q   <= cfg_len;

      if (xfer) begin
        if (last) begin
          addr_cnt <= start_q;
          rem_cnt  <= len_q;
        end else begin
          addr_cnt <= addr_cnt + AW'(1);
          rem_cnt  <= rem_cnt - LW'(1);
        end
      end else if (idle) begin
        if (cfg_start_we) addr_cnt <= cfg_start;
        if (cfg_len_we)   rem_cnt  <= cfg_len;
      end
    end
  end
endmodule

module dma_ring_addr_chk #(
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sample_valid,
  input logic          dma_req,
  input logic          dma_gnt,
  input logic          mem_we,
  input logic          wrap,
  input logic [LW-1:0] len_q
);
  AST_REQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && !dma_req && (len_q != '0) |=> dma_req); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && !dma_gnt |=> dma_req); // R2
  AST_GNT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_req && dma_gnt |=> !mem_we); // R3
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R3
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && dma_gnt |=> mem_we && !dma_req); // R3
  AST_WRAP_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> mem_we); // R6
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid && !dma_req && (len_q == '0) |=> !dma_req); // R8
endmodule

bind dma_ring_addr dma_ring_addr_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .dma_req(dma_req),
  .dma_gnt(dma_gnt), .mem_we(mem_we), .wrap(wrap), .len_q(len_q)
);

// File: tb/tb_dma_ring_addr.sv
`timescale 1ns/1ps
module tb_dma_ring_addr;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_start_we = 1'b0, cfg_len_we = 1'b0;
  logic [15:0] cfg_start = '0, cfg_len = '0;
  logic sample_valid = 1'b0;
  logic [15:0] sample_data = '0;
  logic dma_req, dma_gnt = 1'b0, mem_we, wrap;
  logic [15:0] mem_addr, mem_wdata;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  dma_ring_addr dut (
    .clk(clk), .rst_n(rst_n), .cfg_start_we(cfg_start_we), .cfg_start(cfg_start),
    .cfg_len_we(cfg_len_we), .cfg_len(cfg_len), .sample_valid(sample_valid),
    .sample_data(sample_data), .dma_req(dma_req), .dma_gnt(dma_gnt),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .wrap(wrap)
  );

  // {data, grant delay, expected address, expected wrap} for start 0x1000, length 3
  localparam logic [36:0] VEC [7] = '{
    {16'hA001, 4'd0, 16'h1000, 1'b0},
    {16'hA002, 4'd2, 16'h1001, 1'b0},
    {16'hA003, 4'd1, 16'h1002, 1'b1},
    {16'hA004, 4'd3, 16'h1000, 1'b0},
    {16'hA005, 4'd0, 16'h1001, 1'b0},
    {16'hA006, 4'd5, 16'h1002, 1'b1},
    {16'hA007, 4'd1, 16'h1000, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(input bit ws, input logic [15:0] s, input bit wl, input logic [15:0] l);
    @(negedge clk);
    cfg_start_we = ws; cfg_start = s; cfg_len_we = wl; cfg_len = l;
    @(negedge clk);
    cfg_start_we = 1'b0; cfg_len_we = 1'b0;
  endtask

  task automatic xfer(input logic [15:0] d, input int dly, input logic [15:0] ea, input bit ew);
    @(negedge clk);
    sample_valid = 1'b1; sample_data = d;
    @(negedge clk);
    sample_valid = 1'b0;
    chk("R2 request raised", dma_req, 1);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk("R2 request held", dma_req, 1);
      chk("R3 no strobe before grant", mem_we, 0);
    end
    dma_gnt = 1'b1;
    @(negedge clk);
    dma_gnt = 1'b0;
    chk("R3 strobe after grant", mem_we, 1);
    chk("R3 request dropped", dma_req, 0);
    chk("R4 R5 write address", mem_addr, ea);
    chk("R4 write data", mem_wdata, d);
    chk("R6 wrap flag", wrap, ew);
    @(negedge clk);
    chk("R3 single strobe", mem_we, 0);
    chk("R6 wrap one cycle", wrap, 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset req", dma_req, 0);
    chk("R9 reset we", mem_we, 0);
    chk("R9 reset wrap", wrap, 0);
    chk("R9 reset addr", mem_addr, 0);

    // R3: grant with nothing pending
    dma_gnt = 1'b1;
    @(negedge clk);
    dma_gnt = 1'b0;
    chk("R3 stray grant no strobe", mem_we, 0);
    @(negedge clk);
    chk("R3 stray grant no strobe later", mem_we, 0);

    // R8 and R9: length zero out of reset ignores samples
    @(negedge clk); sample_valid = 1'b1; sample_data = 16'h5555;
    @(negedge clk); sample_valid = 1'b0;
    chk("R8 R9 no request while disabled", dma_req, 0);

    // R1: setup loads counters, then the table walk covers R4 R5 R6
    cfg(1, 16'h1000, 1, 16'd3);
    for (int k = 0; k < 7; k++)
      xfer(VEC[k][36:21], int'(VEC[k][20:17]), VEC[k][16:1], VEC[k][0]);

    // R7: start rewritten while a request is pending
    @(negedge clk); sample_valid = 1'b1; sample_data = 16'hB001;
    @(negedge clk); sample_valid = 1'b0;
    cfg_start_we = 1'b1; cfg_start = 16'h2000;
    @(negedge clk); cfg_start_we = 1'b0;
    chk("R7 still pending", dma_req, 1);
    dma_gnt = 1'b1;
    @(negedge clk); dma_gnt = 1'b0;
    chk("R7 pending write keeps address", mem_addr, 16'h1001);
    chk("R7 pending write no wrap", wrap, 0);
    xfer(16'hB002, 0, 16'h1002, 1);
    xfer(16'hB003, 0, 16'h2000, 0);

    // R1: idle reconfiguration takes effect at once
    cfg(1, 16'h3000, 1, 16'd2);
    xfer(16'hC001, 1, 16'h3000, 0);
    xfer(16'hC002, 0, 16'h3001, 1);
    xfer(16'hC003, 0, 16'h3000, 0);

    // R6: single-word region wraps on every transfer
    cfg(1, 16'h0040, 1, 16'd1);
    xfer(16'hD001, 0, 16'h0040, 1);
    xfer(16'hD002, 2, 16'h0040, 1);

    // R8: disabled again
    cfg(0, 16'h0, 1, 16'd0);
    @(negedge clk); sample_valid = 1'b1; sample_data = 16'h7777;
    @(negedge clk); sample_valid = 1'b0;
    chk("R8 no request at zero length", dma_req, 0);
    dma_gnt = 1'b1;
    @(negedge clk); dma_gnt = 1'b0;
    chk("R8 no write at zero length", mem_we, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule